// File: doc/BRIEF.md
# Board Control Register Block

This peripheral gives software on an FPGA evaluation board a handful of board-level controls and facts through a simple word-wide bus. The bus has a byte address, a read strobe, a write strobe and write and read data, and it completes one access per cycle with no wait states. Inside a 64 KiB window the block answers with a fixed build-date code and the processor clock rate, which is set as a parameter when the chip is built. It holds an LED register that software can write and read back. It samples the DIP switch inputs through a synchronizer.

Writing one exact key to a dedicated offset makes the block raise a single-cycle reset request toward the board's reset controller. Only that one value has this effect, so a stray write cannot reboot the board. Every other offset in the window reads as zero and ignores writes.

Top module: `board_ctrl_regs`

## Requirements
- R1: During and right after reset (active-low `rst_n`), `led_out`, `bus_rdata` and `sys_rst_req` are zero, and a read of the switch register at offset 0xC returns zero.
- R2: A read at offset 0x0 returns the build-date code 0x09272011. Writes to this offset have no effect.
- R3: A read at offset 0x4 returns the parameter `CLK_HZ`, which is 50000000 (0x02FAF080) by default. Writes to this offset have no effect.
- R4: A write at offset 0x8 stores write-data bits [7:0] in the LED register, where 1 means on. `led_out` shows the stored value from the next cycle. A read at 0x8 returns the stored value in bits [7:0] and zero in bits [31:8].
- R5: A read at offset 0xC returns the DIP switch state (1 = on) in bits [7:0]. A change on `dip_in` is readable three clock edges after it is applied: two synchronizer flops, then the switch register.
- R6: A write of exactly 0x0000DEAD at offset 0x10 makes `sys_rst_req` high for exactly the one cycle after the clock edge that samples the write.
- R7: A write at offset 0x10 of any other value, including 0x0001DEAD, leaves `sys_rst_req` low.
- R8: A read at any offset other than 0x0, 0x4, 0x8 and 0xC returns zero. This includes offset 0x10, unaligned offsets such as 0x2, offset 0x14 and offset 0xFFFC.
- R9: A write at any offset other than 0x8 and 0x10 leaves `led_out` unchanged.
- R10: Read data is registered. `bus_rdata` is valid in the cycle after the read strobe and holds that value until the next read.
- R11: When a read and a write at offset 0x8 happen in the same cycle, the read returns the value the LED register held before the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | 16 | Byte offset within the window |
| bus_rd | input | 1 | Read strobe, one access per cycle |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| dip_in | input | 8 | Asynchronous DIP switch inputs |
| led_out | output | 8 | LED drive, 1 = on |
| sys_rst_req | output | 1 | One-cycle board reset request |

## Verification
The assertions assume that the strobes, address and write data are stable at every rising edge and carry no X. They assume that a read and a write in the same cycle target the same offset. The LED and read-data properties rely on this. The bench drives all bus inputs on the falling edge and only ever issues a combined read and write at offset 0x8. It changes `dip_in` only between accesses and waits more than three edges before reading the switches, so the synchronizer latency is never in question.

// File: rtl/bcr_pkg.sv
package bcr_pkg;

    localparam int unsigned OFF_ID   = 'h00;
    localparam int unsigned OFF_FREQ = 'h04;
    localparam int unsigned OFF_LED  = 'h08;
    localparam int unsigned OFF_SW   = 'h0C;
    localparam int unsigned OFF_RST  = 'h10;

    typedef enum logic [2:0] {
        SEL_ID   = 3'd0,
        SEL_FREQ = 3'd1,
        SEL_LED  = 3'd2,
        SEL_SW   = 3'd3,
        SEL_RST  = 3'd4,
        SEL_NONE = 3'd5
    } reg_sel_e;

endpackage

// File: rtl/bcr_decode.sv
module bcr_decode
    import bcr_pkg::*;
#(
    parameter int unsigned ADDR_W = 16
) (
    input  logic [ADDR_W-1:0] addr,
    output reg_sel_e          sel
);

    always_comb begin
        if (addr == ADDR_W'(OFF_ID))        sel = SEL_ID;
        else if (addr == ADDR_W'(OFF_FREQ)) sel = SEL_FREQ;
        else if (addr == ADDR_W'(OFF_LED))  sel = SEL_LED;
        else if (addr == ADDR_W'(OFF_SW))   sel = SEL_SW;
        else if (addr == ADDR_W'(OFF_RST))  sel = SEL_RST;
        else                                sel = SEL_NONE;
    end

endmodule

// File: rtl/bcr_sync.sv
module bcr_sync #(
    parameter int unsigned W      = 8,
    parameter int unsigned STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] din,
    output logic [W-1:0] dout
);

    logic [W-1:0] st_d [STAGES];
    logic [W-1:0] st_q [STAGES];

    always_comb begin
        st_d[0] = din;
        for (int i = 1; i < STAGES; i++) begin
            st_d[i] = st_q[i-1];
        end
    end

    generate
        for (genvar g = 0; g < STAGES; g++) begin : g_stage
            always_ff @(posedge clk) begin
                if (!rst_n) st_q[g] <= '0;
                else        st_q[g] <= st_d[g];
            end
        end
    endgenerate

    assign dout = st_q[STAGES-1];

endmodule

// File: rtl/bcr_rstkey.sv
module bcr_rstkey #(
    parameter int unsigned       DATA_W = 32,
    parameter logic [DATA_W-1:0] KEY    = 32'h0000_DEAD
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_hit,
    input  logic [DATA_W-1:0] wdata,
    output logic              req
);

    logic req_d, req_q;

    always_comb begin
        req_d = wr_hit && (wdata == KEY);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) req_q <= 1'b0;
        else        req_q <= req_d;
    end

    assign req = req_q;

endmodule

// File: rtl/board_ctrl_regs.sv
module board_ctrl_regs
    import bcr_pkg::*;
#(
    parameter int unsigned       ADDR_W     = 16,
    parameter int unsigned       DATA_W     = 32,
    parameter int unsigned       LED_W      = 8,
    parameter int unsigned       SW_W       = 8,
    parameter int unsigned       SYNC_DEPTH = 2,
    parameter logic [DATA_W-1:0] BUILD_CODE = 32'h0927_2011,
    parameter logic [DATA_W-1:0] CLK_HZ     = 32'd50_000_000,
    parameter logic [DATA_W-1:0] RESET_KEY  = 32'h0000_DEAD
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_rd,
    input  logic              bus_wr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic [SW_W-1:0]   dip_in,
    output logic [LED_W-1:0]  led_out,
    output logic              sys_rst_req
);

    typedef struct packed {
        logic [LED_W-1:0]  led;
        logic [SW_W-1:0]   sw;
        logic [DATA_W-1:0] rdata;
    } state_t;

    state_t   st_d, st_q;
    reg_sel_e sel;
    logic [SW_W-1:0] sw_sync;

    bcr_decode #(.ADDR_W(ADDR_W)) u_dec (
        .addr (bus_addr),
        .sel  (sel)
    );

    bcr_sync #(.W(SW_W), .STAGES(SYNC_DEPTH)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .din   (dip_in),
        .dout  (sw_sync)
    );

    bcr_rstkey #(.DATA_W(DATA_W), .KEY(RESET_KEY)) u_key (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_hit (bus_wr && (sel == SEL_RST)),
        .wdata  (bus_wdata),
        .req    (sys_rst_req)
    );

    always_comb begin
        st_d    = st_q;
        st_d.sw = sw_sync;
        if (bus_wr && (sel == SEL_LED)) begin
            st_d.led = bus_wdata[LED_W-1:0];
        end
        if (bus_rd) begin
            unique case (sel)
                SEL_ID:   st_d.rdata = BUILD_CODE;
                SEL_FREQ: st_d.rdata = CLK_HZ;
                SEL_LED:  st_d.rdata = DATA_W'(st_q.led);
                SEL_SW:   st_d.rdata = DATA_W'(st_q.sw);
                default:  st_d.rdata = '0;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign bus_rdata = st_q.rdata;
    assign led_out   = st_q.led;

endmodule

// File: rtl/bcr_chk.sv
module bcr_chk #(
    parameter int unsigned       ADDR_W     = 16,
    parameter int unsigned       DATA_W     = 32,
    parameter int unsigned       LED_W      = 8,
    parameter logic [DATA_W-1:0] BUILD_CODE = 32'h0927_2011,
    parameter logic [DATA_W-1:0] CLK_HZ     = 32'd50_000_000,
    parameter logic [DATA_W-1:0] RESET_KEY  = 32'h0000_DEAD
) (
    input logic              clk,
    input logic              rst_n,
    input logic [ADDR_W-1:0] bus_addr,
    input logic              bus_rd,
    input logic              bus_wr,
    input logic [DATA_W-1:0] bus_wdata,
    input logic [DATA_W-1:0] bus_rdata,
    input logic [LED_W-1:0]  led_out,
    input logic              sys_rst_req
);

    logic at_id, at_freq, at_led, at_sw, at_rst, key_wr;
    assign at_id   = (bus_addr == ADDR_W'('h00));
    assign at_freq = (bus_addr == ADDR_W'('h04));
    assign at_led  = (bus_addr == ADDR_W'('h08));
    assign at_sw   = (bus_addr == ADDR_W'('h0C));
    assign at_rst  = (bus_addr == ADDR_W'('h10));
    assign key_wr  = bus_wr && at_rst && (bus_wdata == RESET_KEY);

    // R2
    id_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bus_rd && at_id |=> bus_rdata == BUILD_CODE);

    // R3
    freq_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bus_rd && at_freq |=> bus_rdata == CLK_HZ);

    // R4
    led_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bus_wr && at_led |=> led_out == $past(bus_wdata[LED_W-1:0]));

    // R6
    key_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        key_wr |=> sys_rst_req);

    // R7
    no_spurious_rst_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !key_wr |=> !sys_rst_req);

    // R8
    undecoded_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bus_rd && !(at_id || at_freq || at_led || at_sw) |=> bus_rdata == '0);

    // R9
    led_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(bus_wr && at_led) |=> $stable(led_out));

    // R10
    rdata_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_rd |=> $stable(bus_rdata));

    // R11
    led_old_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bus_rd && at_led |=> bus_rdata == DATA_W'($past(led_out)));

endmodule

bind board_ctrl_regs bcr_chk #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .LED_W(LED_W),
    .BUILD_CODE(BUILD_CODE), .CLK_HZ(CLK_HZ), .RESET_KEY(RESET_KEY)
) u_chk (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_rd(bus_rd),
    .bus_wr(bus_wr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .led_out(led_out), .sys_rst_req(sys_rst_req)
);

// File: tb/tb_board_ctrl_regs.sv
`timescale 1ns/1ps
module tb_board_ctrl_regs;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] bus_addr = '0;
    logic        bus_rd = 1'b0;
    logic        bus_wr = 1'b0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [7:0]  dip_in = '0;
    logic [7:0]  led_out;
    logic        sys_rst_req;

    int total = 0;
    int bad   = 0;

    always #2.5 clk = ~clk;

    board_ctrl_regs dut (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_rd(bus_rd),
        .bus_wr(bus_wr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .dip_in(dip_in), .led_out(led_out), .sys_rst_req(sys_rst_req)
    );

    typedef struct packed {
        logic        wr;
        logic        rd;
        logic [15:0] addr;
        logic [31:0] wdata;
        logic [31:0] exp_rd;
        logic [7:0]  exp_led;
    } vec_t;

    localparam int NV = 12;
    localparam vec_t VEC [NV] = '{
        '{1'b0, 1'b1, 16'h0000, 32'h0,         32'h0927_2011, 8'h00}, // R2
        '{1'b0, 1'b1, 16'h0004, 32'h0,         32'h02FA_F080, 8'h00}, // R3
        '{1'b1, 1'b0, 16'h0008, 32'h0000_00A5, 32'h0,         8'hA5}, // R4
        '{1'b0, 1'b1, 16'h0008, 32'h0,         32'h0000_00A5, 8'hA5}, // R4
        '{1'b1, 1'b0, 16'h0008, 32'hFFFF_FF3C, 32'h0,         8'h3C}, // R4
        '{1'b0, 1'b1, 16'h0008, 32'h0,         32'h0000_003C, 8'h3C}, // R4
        '{1'b1, 1'b0, 16'h0000, 32'h0000_1234, 32'h0,         8'h3C}, // R9
        '{1'b1, 1'b0, 16'h000C, 32'h0000_00FF, 32'h0,         8'h3C}, // R9
        '{1'b0, 1'b1, 16'h0014, 32'h0,         32'h0,         8'h3C}, // R8
        '{1'b0, 1'b1, 16'h0002, 32'h0,         32'h0,         8'h3C}, // R8
        '{1'b0, 1'b1, 16'hFFFC, 32'h0,         32'h0,         8'h3C}, // R8
        '{1'b0, 1'b1, 16'h0010, 32'h0,         32'h0,         8'h3C}  // R8
    };

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Drive on a falling edge, release on the next falling edge; outputs are then settled.
    task automatic access(input logic wr, input logic rd, input logic [15:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_wr = wr; bus_rd = rd; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0; bus_rd = 1'b0;
    endtask

    initial begin
        #200000;
        bad++; total++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        dip_in = 8'h5A;
        repeat (4) @(negedge clk);
        // R1 reset state
        check("R1 led", {24'h0, led_out}, 32'h0);
        check("R1 rdata", bus_rdata, 32'h0);
        check("R1 rstreq", {31'h0, sys_rst_req}, 32'h0);
        rst_n = 1'b1;
        access(1'b0, 1'b1, 16'h000C, 32'h0);
        check("R1 sw after reset", bus_rdata, 32'h0);

        dip_in = 8'h00;
        repeat (4) @(negedge clk);
        for (int i = 0; i < NV; i++) begin
            access(VEC[i].wr, VEC[i].rd, VEC[i].addr, VEC[i].wdata);
            if (VEC[i].rd) check("R2/R3/R4/R8 vec rdata", bus_rdata, VEC[i].exp_rd);
            check("R4/R9 vec led", {24'h0, led_out}, {24'h0, VEC[i].exp_led});
            check("R7 vec no reset", {31'h0, sys_rst_req}, 32'h0);
        end

        // R5 switch sampling latency
        @(negedge clk) dip_in = 8'hC3;
        repeat (3) @(negedge clk);
        access(1'b0, 1'b1, 16'h000C, 32'h0);
        check("R5 switches", bus_rdata, 32'h0000_00C3);
        dip_in = 8'h81;
        repeat (4) @(negedge clk);
        access(1'b0, 1'b1, 16'h000C, 32'h0);
        check("R5 switches second", bus_rdata, 32'h0000_0081);

        // R10 read data holds through a non-read cycle
        access(1'b1, 1'b0, 16'h0008, 32'h0000_0011);
        check("R10 hold", bus_rdata, 32'h0000_0081);

        // R11 simultaneous read and write at LED
        access(1'b1, 1'b1, 16'h0008, 32'h0000_0077);
        check("R11 old value", bus_rdata, 32'h0000_0011);
        check("R11 new led", {24'h0, led_out}, 32'h0000_0077);

        // R7 near-miss keys
        access(1'b1, 1'b0, 16'h0010, 32'h0001_DEAD);
        check("R7 upper bits", {31'h0, sys_rst_req}, 32'h0);
        access(1'b1, 1'b0, 16'h0014, 32'h0000_DEAD);
        check("R7 wrong offset", {31'h0, sys_rst_req}, 32'h0);

        // R6 key write gives one-cycle pulse
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = 16'h0010; bus_wdata = 32'h0000_DEAD;
        @(negedge clk);
        bus_wr = 1'b0;
        check("R6 pulse high", {31'h0, sys_rst_req}, 32'h1);
        @(negedge clk);
        check("R6 pulse low", {31'h0, sys_rst_req}, 32'h0);
        check("R9 led after key", {24'h0, led_out}, 32'h0000_0077);

        // R1 reset clears LED mid-run
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        check("R1 led cleared", {24'h0, led_out}, 32'h0);
        rst_n = 1'b1;

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule